// File: doc/BRIEF.md
# Multiplexed Processor Bus Register Slave

This block sits on a processor's 32-bit multiplexed address/data bus and acts as the slave for one region of the address space. When the address strobe is high, it captures the upper address bits from the shared bus. The two word-select bits come from their own pins. It then sorts the address into one of fourteen regions, using the top nibble as the region number.

If the region is the internal register window, the slave serves every data beat from a small register file. It drives an active-low acknowledge for each beat, honours the byte enables, and steps the word address on each beat until the processor flags the last beat. If the region number is not mapped, the slave ends the cycle with a single-cycle active-low bus error. The other mapped regions belong to external timing logic. For those the slave only reports the region number and stays silent on the handshake lines.

A transaction runs as follows. In the first cycle the strobe is high, the cycle-in-progress line is low and the bus carries the address. Each later cycle is one data beat. On a beat the acknowledge (or bus error) is valid in that same cycle, and a write is stored at the clock edge that ends the beat.

Top module: `lbus_slave`

## Requirements
- R1: After synchronous reset, the acknowledge and bus-error outputs are high, the read-data enable is low, and every internal register reads as zero.
- R2: In a cycle where the strobe is high and cycle-in-progress is low, the slave captures bus bits 31:4 and the separate 2-bit input as address bits 3:2. From the next cycle on, `region_o` shows address bits 31:28.
- R3: While cycle-in-progress is high, no address is captured and neither acknowledge nor bus error is driven. Raising it in the middle of a burst abandons the transaction, so lowering it again without a new address gives no acknowledge.
- R4: The register window is region 13. For a read there, every data cycle drives acknowledge low, drives the read-data enable high, and places the register whose index is {address bit 4, current word bits} on `bus_ad_o`.
- R5: For a write (write-status low, captured with the address), each acknowledged beat stores only the bytes whose active-low enable is low. Enable bit 0 covers data bits 7:0, bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24.
- R6: On a read, byte lanes whose enable is high are returned as zero.
- R7: The word bits start at the captured address bits 3:2 and advance by one on each acknowledged beat, wrapping inside the 16-byte block.
- R8: An acknowledged beat with last-data low ends the transaction. No acknowledge follows, even while cycle-in-progress stays low.
- R9: Region numbers 14 and 15 are unmapped. In the first data cycle the slave drives bus error low for exactly one cycle, gives no acknowledge, and ends the transaction.
- R10: For mapped regions 0 to 12, the slave drives neither acknowledge nor bus error.
- R11: Acknowledge and bus error are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_ad_i | input | 32 | Shared bus: address in the address phase, write data in data beats |
| bus_ad_o | output | 32 | Read data for the register window |
| bus_ad_oe | output | 1 | High while the slave drives read data |
| lo_addr_i | input | 2 | Address bits 3:2 |
| ale_i | input | 1 | Address strobe, active high |
| cip_n_i | input | 1 | Cycle in progress, active low |
| wr_n_i | input | 1 | Write status, active low (high means read) |
| be_n_i | input | 4 | Byte enables, active low |
| last_n_i | input | 1 | Last data beat, active low |
| ack_n_o | output | 1 | Beat acknowledge, active low |
| berr_n_o | output | 1 | Bus error, active low |
| region_o | output | 4 | Decoded region number of the captured address |

## Verification
Two things can fall due in the same cycle: the acknowledge of a beat and the end of the transaction it triggers. Equally, a word-address step can coincide with a byte-masked write. The bench provokes both with bursts that start at a mid-block word, so the word index wraps, and with partial byte enables. A final beat is followed by a cycle with cycle-in-progress held low, and the bench judges that no stray acknowledge appears. Read results are queued by the driver from a byte-level model and compared when each acknowledged read beat appears. An unmapped access is checked so that the one-cycle error pulse never coincides with an acknowledge.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    localparam int DW          = 32;
    localparam int NBE         = DW / 8;
    localparam int REGION_W    = 4;
    localparam int NUM_REGIONS = 14;
    localparam int REG_REGION  = 13;
    localparam int RF_IDX_W    = 3;
    localparam int WORD_W      = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic [DW-1:4] hi;
        logic          wr;
    } lat_addr_t;

    typedef struct packed {
        logic [REGION_W-1:0] idx;
        logic                mapped;
        logic                is_reg;
    } region_t;

    function automatic logic [DW-1:0] lane_mask(input logic [NBE-1:0] be_n);
        logic [DW-1:0] m;
        for (int l = 0; l < NBE; l++) begin
            m[8*l +: 8] = {8{~be_n[l]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/lbus_addr_latch.sv
module lbus_addr_latch
    import lbus_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int WRD_W  = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              cip_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [WRD_W-1:0]  lo,
    input  logic              wr_n,
    input  logic              beat_adv,
    output lat_addr_t         lat,
    output logic [WRD_W-1:0]  word
);

    logic capture;
    assign capture = ale && !cip_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat  <= '0;
            word <= '0;
        end else if (capture) begin
            lat.hi <= ad[DATA_W-1:4];
            lat.wr <= ~wr_n;
            word   <= lo;
        end else if (beat_adv) begin
            word <= word + 1'b1;
        end
    end

endmodule

// File: rtl/lbus_region_dec.sv
module lbus_region_dec
    import lbus_pkg::*;
#(
    parameter int IDX_W   = REGION_W,
    parameter int N_REG   = NUM_REGIONS,
    parameter int REG_SEL = REG_REGION
) (
    input  logic [IDX_W-1:0] top_bits,
    output region_t          region
);

    always_comb begin
        region.idx    = top_bits;
        region.mapped = 1'b0;
        for (int r = 0; r < N_REG; r++) begin
            if (top_bits == IDX_W'(r)) region.mapped = 1'b1;
        end
        region.is_reg = region.mapped && (top_bits == IDX_W'(REG_SEL));
    end

endmodule

// File: rtl/lbus_regfile.sv
module lbus_regfile
    import lbus_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int IDX_W  = RF_IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W/8-1:0] be_n,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);

    localparam int NREGS = 1 << IDX_W;
    localparam int LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_q [NREGS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NREGS; i++) lane_q[i] <= '0;
            end else if (we && !be_n[l]) begin
                lane_q[idx] <= wdata[8*l +: 8];
            end
        end

        assign rdata[8*l +: 8] = be_n[l] ? 8'h00 : lane_q[idx];
    end

endmodule

// File: rtl/lbus_hs_fsm.sv
module lbus_hs_fsm
    import lbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ale,
    input  logic    cip_n,
    input  logic    last_n,
    input  region_t region,
    output logic    ack,
    output logic    berr,
    output logic    beat_adv
);

    hs_state_e state_q, state_d;
    logic      live;

    assign live     = (state_q == ST_DATA) && !cip_n && !ale;
    assign ack      = live && region.is_reg;
    assign berr     = live && !region.mapped;
    assign beat_adv = ack && last_n;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (ale && !cip_n) state_d = ST_DATA;
            ST_DATA: begin
                if (cip_n)                 state_d = ST_IDLE;
                else if (berr)             state_d = ST_IDLE;
                else if (ack && !last_n)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/lbus_slave.sv
module lbus_slave
    import lbus_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus_ad_i,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_ad_oe,
    input  logic [1:0]    lo_addr_i,
    input  logic          ale_i,
    input  logic          cip_n_i,
    input  logic          wr_n_i,
    input  logic [3:0]    be_n_i,
    input  logic          last_n_i,
    output logic          ack_n_o,
    output logic          berr_n_o,
    output logic [3:0]    region_o
);

    localparam int HI_IDX_W = RF_IDX_W - WORD_W;

    lat_addr_t           lat;
    logic [WORD_W-1:0]   word;
    region_t             region;
    logic                ack, berr, beat_adv;
    logic [RF_IDX_W-1:0] rf_idx;
    logic [DW-1:0]       rf_rdata;

    lbus_addr_latch #(.DATA_W(DW), .WRD_W(WORD_W)) u_latch (
        .clk(clk), .rst(rst), .ale(ale_i), .cip_n(cip_n_i), .ad(bus_ad_i),
        .lo(lo_addr_i), .wr_n(wr_n_i), .beat_adv(beat_adv),
        .lat(lat), .word(word)
    );

    lbus_region_dec #(.IDX_W(REGION_W), .N_REG(NUM_REGIONS), .REG_SEL(REG_REGION)) u_dec (
        .top_bits(lat.hi[DW-1 -: REGION_W]), .region(region)
    );

    lbus_hs_fsm u_fsm (
        .clk(clk), .rst(rst), .ale(ale_i), .cip_n(cip_n_i), .last_n(last_n_i),
        .region(region), .ack(ack), .berr(berr), .beat_adv(beat_adv)
    );

    assign rf_idx = {lat.hi[4 +: HI_IDX_W], word};

    lbus_regfile #(.DATA_W(DW), .IDX_W(RF_IDX_W)) u_rf (
        .clk(clk), .rst(rst), .we(ack && lat.wr), .idx(rf_idx),
        .be_n(be_n_i), .wdata(bus_ad_i), .rdata(rf_rdata)
    );

    assign bus_ad_oe = ack && !lat.wr;
    assign bus_ad_o  = bus_ad_oe ? rf_rdata : '0;
    assign ack_n_o   = ~ack;
    assign berr_n_o  = ~berr;
    assign region_o  = region.idx;

    // R11
    ack_berr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ack_n_o && !berr_n_o));

    // R9
    berr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !berr_n_o |=> berr_n_o);

    // R9
    berr_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        !berr_n_o |-> !region.mapped);

    // R8
    last_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n_o && !last_n_i) |=> ack_n_o);

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n_o && last_n_i) |=> (word == $past(word) + 2'd1));

endmodule

// File: tb/tb_lbus_slave.sv
module tb_lbus_slave;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_ad_i, bus_ad_o;
    logic        bus_ad_oe;
    logic [1:0]  lo_addr_i;
    logic        ale_i, cip_n_i, wr_n_i, last_n_i;
    logic [3:0]  be_n_i;
    logic        ack_n_o, berr_n_o;
    logic [3:0]  region_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] model [8];
    logic [31:0] wbuf  [4];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    lbus_slave dut (
        .clk(clk), .rst(rst), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
        .bus_ad_oe(bus_ad_oe), .lo_addr_i(lo_addr_i), .ale_i(ale_i),
        .cip_n_i(cip_n_i), .wr_n_i(wr_n_i), .be_n_i(be_n_i),
        .last_n_i(last_n_i), .ack_n_o(ack_n_o), .berr_n_o(berr_n_o),
        .region_o(region_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [3:0] ben);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[8*l +: 8] = ben[l] ? 8'h00 : 8'hFF;
        return m;
    endfunction

    // Scoreboard monitor: compares every acknowledged read beat
    always @(negedge clk) begin
        #4;
        if (!rst && !ack_n_o && bus_ad_oe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected read beat", bus_ad_o, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_ad_o == e, t, bus_ad_o, e);
            end
        end
    end

    task automatic idle_bus();
        ale_i = 1'b0; cip_n_i = 1'b1; wr_n_i = 1'b1; be_n_i = 4'hF;
        last_n_i = 1'b1; bus_ad_i = '0; lo_addr_i = '0;
    endtask

    task automatic addr_phase(input logic [31:0] addr, input bit wr, input logic [3:0] ben);
        @(negedge clk);
        ale_i = 1'b1; cip_n_i = 1'b0; bus_ad_i = {addr[31:4], 4'h0};
        lo_addr_i = addr[3:2]; wr_n_i = !wr; be_n_i = ben; last_n_i = 1'b1;
    endtask

    // Driver: runs a register-window transfer and queues expected read data
    task automatic xfer(input logic [31:0] addr, input bit wr, input logic [3:0] ben,
                        input int n, input string tag);
        logic [1:0] lo;
        int         idx;
        lo = addr[3:2];
        addr_phase(addr, wr, ben);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            ale_i = 1'b0;
            idx = {addr[4], lo};
            last_n_i = (b == n - 1) ? 1'b0 : 1'b1;
            if (wr) begin
                bus_ad_i = wbuf[b];
                model[idx] = (model[idx] & ~mask_of(ben)) | (wbuf[b] & mask_of(ben));
            end else begin
                bus_ad_i = '0;
                exp_q.push_back(model[idx] & mask_of(ben));
                tag_q.push_back(tag);
            end
            #4;
            check(ack_n_o == 1'b0, "R4 beat acknowledge", 32'(ack_n_o), 32'h0);
            if (b == 0) check(region_o == addr[31:28], "R2 region", 32'(region_o), 32'(addr[31:28]));
            lo = lo + 2'd1;
        end
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        idle_bus();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        // R1 reset state
        check(ack_n_o == 1'b1, "R1 ack idle", 32'(ack_n_o), 32'h1);
        check(berr_n_o == 1'b1, "R1 berr idle", 32'(berr_n_o), 32'h1);
        check(bus_ad_oe == 1'b0, "R1 oe idle", 32'(bus_ad_oe), 32'h0);
        xfer(32'hD000_0000, 1'b0, 4'h0, 1, "R1 register reset value");

        // R5 full write, then byte-masked write
        wbuf[0] = 32'hA5A5_1234;
        xfer(32'hD000_0004, 1'b1, 4'h0, 1, "R5 write");
        wbuf[0] = 32'hFFFF_FFFF;
        xfer(32'hD000_0004, 1'b1, 4'b1010, 1, "R5 masked write");
        xfer(32'hD000_0004, 1'b0, 4'h0, 1, "R5 readback");
        // R6 disabled lanes read as zero
        xfer(32'hD000_0004, 1'b0, 4'b0101, 1, "R6 lane zeroing");

        // R7 burst starting at word 2 of the upper block, wraps 6,7,4,5
        wbuf[0] = 32'h1111_1111; wbuf[1] = 32'h2222_2222;
        wbuf[2] = 32'h3333_3333; wbuf[3] = 32'h4444_4444;
        xfer(32'hD000_0018, 1'b1, 4'h0, 4, "R7 burst write");
        xfer(32'hD000_0010, 1'b0, 4'h0, 4, "R7 burst read");
        xfer(32'hD000_001C, 1'b0, 4'h0, 3, "R7 burst read wrap");

        // R8 last beat ends the cycle even with cycle-in-progress held low
        addr_phase(32'hD000_0000, 1'b0, 4'h0);
        @(negedge clk);
        ale_i = 1'b0; last_n_i = 1'b0;
        exp_q.push_back(model[0]); tag_q.push_back("R8 read");
        @(negedge clk);
        last_n_i = 1'b1;
        #4;
        check(ack_n_o == 1'b1, "R8 no ack after last", 32'(ack_n_o), 32'h1);
        @(negedge clk);
        #4;
        check(ack_n_o == 1'b1, "R8 still idle", 32'(ack_n_o), 32'h1);
        @(negedge clk);
        idle_bus();

        // R10 mapped external region: silent handshake
        addr_phase(32'h3000_0040, 1'b0, 4'h0);
        @(negedge clk);
        ale_i = 1'b0;
        #4;
        check(region_o == 4'd3, "R2 region external", 32'(region_o), 32'h3);
        for (int k = 0; k < 3; k++) begin
            check(ack_n_o == 1'b1 && berr_n_o == 1'b1, "R10 silent",
                  {30'h0, berr_n_o, ack_n_o}, 32'h3);
            @(negedge clk);
            #4;
        end
        @(negedge clk);
        idle_bus();

        // R9 unmapped regions 14 and 15
        for (int u = 14; u < 16; u++) begin
            addr_phase({4'(u), 28'h000_0100}, 1'b0, 4'h0);
            @(negedge clk);
            ale_i = 1'b0;
            #4;
            check(berr_n_o == 1'b0 && ack_n_o == 1'b1, "R9 error pulse",
                  {30'h0, berr_n_o, ack_n_o}, 32'h1);
            @(negedge clk);
            #4;
            check(berr_n_o == 1'b1 && ack_n_o == 1'b1, "R9 pulse ends",
                  {30'h0, berr_n_o, ack_n_o}, 32'h3);
            @(negedge clk);
            idle_bus();
        end

        // R3 strobe ignored while no cycle is in progress
        @(negedge clk);
        ale_i = 1'b1; cip_n_i = 1'b1; bus_ad_i = 32'hD000_0000;
        @(negedge clk);
        ale_i = 1'b0; cip_n_i = 1'b0;
        #4;
        check(ack_n_o == 1'b1, "R3 no capture without cycle", 32'(ack_n_o), 32'h1);
        @(negedge clk);
        idle_bus();

        // R3 abort in the middle of a burst
        addr_phase(32'hD000_0000, 1'b0, 4'h0);
        @(negedge clk);
        ale_i = 1'b0;
        exp_q.push_back(model[0]); tag_q.push_back("R3 first beat");
        @(negedge clk);
        cip_n_i = 1'b1;
        #4;
        check(ack_n_o == 1'b1, "R3 no ack while inactive", 32'(ack_n_o), 32'h1);
        @(negedge clk);
        cip_n_i = 1'b0;
        #4;
        check(ack_n_o == 1'b1, "R3 abandoned burst", 32'(ack_n_o), 32'h1);
        @(negedge clk);
        idle_bus();

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule